// File: doc/BRIEF.md
# Glitch-Free Card Clock Generator

This block produces two clock waveforms for a card interface from a single timebase `clk`. The master clock is defined as half the timebase rate, so its period is two `clk` cycles. Every output is a registered level that changes only on rising edges of `clk`. A DC/DC clock is divided from the master clock by an even prescaler (or passed through at divide-by-1) and always has a 50% duty cycle.

The card clock is taken from one of eight sources: the master clock, master/2, master/4, the DC/DC clock, DC/DC/2, DC/DC/4, a synchronised alternate clock, and alternate/2. A new source is adopted only while the card clock is in a low phase and the new source is also low, so no high pulse is ever cut short.

The select inputs are levels. Any change of a select input counts as a request and is checked against ordering rules. A request that breaks a rule is dropped and raises a sticky error flag. A stop input parks the card clock low, and releasing it restarts the card clock with a full high phase.

Top module: `ccg_card_clk`

## Requirements
- R1: During and after reset, `card_clk`, `dcdc_clk` and `sel_err` are 0. After reset the prescaler is code 1 (DC/DC period 4 `clk` cycles) and the card source is code 0 (period 2).
- R2: Prescaler code c on `dck_sel` (0..6) makes `dcdc_clk` high for H cycles and low for H cycles. H is 1 when c is 0 and 2·c otherwise.
- R3: Prescaler code 7 is reserved. Requesting it leaves the divider unchanged and sets `sel_err`.
- R4: The `cclk_sel` encoding gives these card clock periods, in `clk` cycles, at 50% duty:
  - 0 = master (2)
  - 1 = DC/DC (2H)
  - 2 = DC/DC/2 (4H)
  - 3 = DC/DC/4 (8H)
  - 4 = alternate (the period of `alt_clk`)
  - 5 = alternate/2 (twice that)
  - 6 = master/2 (4)
  - 7 = master/4 (8)
- R5: A source change never shortens the high phase that is in progress. The new source is taken up in a common low phase.
- R6: A request that moves between the alternate group {4,5} and the master group {0,1,2,3,6,7} is accepted only while `stop_req` is high and the card clock is parked. Otherwise it is ignored and sets `sel_err`.
- R7: While the prescaler code is 0, only selects 4 and 5 are kept. A request for a master-group select, or a prescaler request for code 0 while a master-group select is in force, is ignored and sets `sel_err`.
- R8: When entering the alternate group, the first request for 4 or 5 only primes the group and does not switch. A following request for the other member of the group performs the switch.
- R9: With `stop_req` high, the card clock goes low at the end of its current high phase and stays low. On release, the first high phase has full length.
- R10: `sel_err` stays high until reset.
- R11: Inside the alternate group, switching between 4 and 5 is allowed while running and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase, twice the master clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| alt_clk | input | 1 | Alternate clock, asynchronous, synchronised inside |
| dck_sel | input | 3 | DC/DC prescaler code request |
| cclk_sel | input | 3 | Card clock source request |
| stop_req | input | 1 | Park the card clock low |
| dcdc_clk | output | 1 | Divided DC/DC clock |
| card_clk | output | 1 | Selected card clock |
| sel_err | output | 1 | Sticky flag for dropped requests |

## Verification
A request is judged in the cycle in which a select input differs from its value one cycle earlier, and `sel_err` is visible one cycle after that. A source change completes within one half period of the slower of the two sources, and a stop takes effect at the end of the current high phase. The bench therefore waits at least two full periods of the slowest source involved before it measures anything. It then measures periods and high times from rising edge to rising edge, sampling on the falling edge of `clk`. The in-progress high pulse during a switch and the first pulse after a stop release are counted sample by sample.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
    localparam int SEL_W = 3;
    localparam int DCK_W = 3;

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [DCK_W-1:0] dck_t;

    localparam sel_t SEL_MASTER = 3'd0;
    localparam sel_t SEL_ALT    = 3'd4;
    localparam sel_t SEL_ALT_H  = 3'd5;
    localparam dck_t DCK_DIV1   = 3'd0;
    localparam dck_t DCK_RESET  = 3'd1;
    localparam dck_t DCK_RSVD   = 3'd7;

    function automatic logic is_alt(input sel_t s);
        return (s == SEL_ALT) || (s == SEL_ALT_H);
    endfunction
endpackage

// File: rtl/ccg_master_div.sv
module ccg_master_div #(
    parameter int TAPS = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TAPS-1:0] taps
);
    typedef struct packed {
        logic [TAPS-1:0] cnt;
    } mdiv_s;

    mdiv_s st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + TAPS'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign taps = st_q.cnt;
endmodule

// File: rtl/ccg_dcdc_div.sv
module ccg_dcdc_div #(
    parameter int MAX_HALF = 12,
    parameter int POST     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ccg_pkg::dck_t   code,
    output logic            dc,
    output logic [POST-1:0] dc_post
);
    localparam int CNT_W = $clog2(MAX_HALF + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dc;
        logic [POST-1:0]  post;
    } ddiv_s;

    ddiv_s            st_d, st_q;
    logic [CNT_W-1:0] half_v;

    always_comb begin
        half_v = (code == ccg_pkg::DCK_DIV1) ? CNT_W'(1) : CNT_W'({code, 1'b0});
        st_d   = st_q;
        if (st_q.cnt >= half_v - CNT_W'(1)) begin
            st_d.cnt = '0;
            st_d.dc  = ~st_q.dc;
            if (!st_q.dc) st_d.post = st_q.post + POST'(1);
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dc      = st_q.dc;
    assign dc_post = st_q.post;
endmodule

// File: rtl/ccg_alt_sync.sv
module ccg_alt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alt_clk,
    output logic a2,
    output logic a2_half
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              half;
    } async_s;

    async_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], alt_clk};
        if (st_q.sync[STAGES-2] && !st_q.sync[STAGES-1]) st_d.half = ~st_q.half;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a2      = st_q.sync[STAGES-1];
    assign a2_half = st_q.half;
endmodule

// File: rtl/ccg_sel_ctrl.sv
module ccg_sel_ctrl
    import ccg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  sel_t                 sel_in,
    input  dck_t                 dck_in,
    input  logic                 stop_req,
    input  logic [(1<<SEL_W)-1:0] src,
    output logic                 card_clk,
    output dck_t                 dck_act,
    output sel_t                 tgt_o,
    output sel_t                 act_o,
    output logic                 sel_err
);
    typedef struct packed {
        sel_t sel_last;
        dck_t dck_last;
        sel_t tgt;
        sel_t act;
        dck_t dck_act;
        logic run;
        logic cclk;
        logic err;
        logic prime;
        logic prime_odd;
    } ctrl_s;

    localparam ctrl_s CTRL_RST = '{
        sel_last: SEL_MASTER, dck_last: DCK_RESET, tgt: SEL_MASTER,
        act: SEL_MASTER, dck_act: DCK_RESET, run: 1'b1, cclk: 1'b0,
        err: 1'b0, prime: 1'b0, prime_odd: 1'b0};

    ctrl_s st_d, st_q;
    logic  halted;

    always_comb begin
        st_d          = st_q;
        halted        = stop_req && !st_q.run;
        st_d.sel_last = sel_in;
        st_d.dck_last = dck_in;

        // source request, judged on a change of the select input
        if (sel_in != st_q.sel_last) begin
            if (sel_in == st_q.tgt) begin
                st_d.prime = 1'b0;
            end else if (is_alt(sel_in) == is_alt(st_q.tgt)) begin
                st_d.tgt = sel_in;
            end else if (!halted) begin
                st_d.err = 1'b1;
            end else if (is_alt(sel_in)) begin
                if (st_q.prime && (st_q.prime_odd != sel_in[0])) begin
                    st_d.tgt   = sel_in;
                    st_d.prime = 1'b0;
                end else begin
                    st_d.prime     = 1'b1;
                    st_d.prime_odd = sel_in[0];
                end
            end else if (st_q.dck_act == DCK_DIV1) begin
                st_d.err = 1'b1;
            end else begin
                st_d.tgt   = sel_in;
                st_d.prime = 1'b0;
            end
        end

        // prescaler request, judged against the updated source target
        if (dck_in != st_q.dck_last) begin
            if (dck_in == DCK_RSVD) begin
                st_d.err = 1'b1;
            end else if ((dck_in == DCK_DIV1) && !is_alt(st_d.tgt)) begin
                st_d.err = 1'b1;
            end else begin
                st_d.dck_act = dck_in;
            end
        end

        // adopt the target only in a shared low phase, or while parked
        if (st_d.tgt != st_q.act) begin
            if (!st_q.run || (!st_q.cclk && !src[st_d.tgt])) st_d.act = st_d.tgt;
        end

        if (st_q.run && stop_req && !st_q.cclk) begin
            st_d.run = 1'b0;
        end else if (!st_q.run && !stop_req && !src[st_d.act]) begin
            st_d.run = 1'b1;
        end

        st_d.cclk = st_d.run && src[st_d.act];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CTRL_RST;
        else        st_q <= st_d;
    end

    assign card_clk = st_q.cclk;
    assign dck_act  = st_q.dck_act;
    assign tgt_o    = st_q.tgt;
    assign act_o    = st_q.act;
    assign sel_err  = st_q.err;
endmodule

// File: rtl/ccg_card_clk.sv
module ccg_card_clk #(
    parameter int MAX_HALF    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alt_clk,
    input  logic [2:0] dck_sel,
    input  logic [2:0] cclk_sel,
    input  logic       stop_req,
    output logic       dcdc_clk,
    output logic       card_clk,
    output logic       sel_err
);
    import ccg_pkg::*;

    localparam int MTAPS = 3;
    localparam int POST  = 2;
    localparam int NSRC  = 1 << SEL_W;

    logic [MTAPS-1:0] mtaps;
    logic             dc;
    logic [POST-1:0]  dc_post;
    logic             a2, a2_half;
    dck_t             dck_act;
    sel_t             sel_tgt, sel_act;
    logic [NSRC-1:0]  src;

    ccg_master_div #(.TAPS(MTAPS)) u_mdiv (
        .clk(clk), .rst_n(rst_n), .taps(mtaps)
    );

    ccg_dcdc_div #(.MAX_HALF(MAX_HALF), .POST(POST)) u_ddiv (
        .clk(clk), .rst_n(rst_n), .code(dck_act), .dc(dc), .dc_post(dc_post)
    );

    ccg_alt_sync #(.STAGES(SYNC_STAGES)) u_async (
        .clk(clk), .rst_n(rst_n), .alt_clk(alt_clk), .a2(a2), .a2_half(a2_half)
    );

    // source order follows the select encoding
    assign src = {mtaps[2], mtaps[1], a2_half, a2, dc_post[1], dc_post[0], dc, mtaps[0]};

    ccg_sel_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_in(cclk_sel), .dck_in(dck_sel),
        .stop_req(stop_req), .src(src), .card_clk(card_clk), .dck_act(dck_act),
        .tgt_o(sel_tgt), .act_o(sel_act), .sel_err(sel_err)
    );

    assign dcdc_clk = dc;
endmodule

// File: rtl/ccg_checker.sv
module ccg_checker (
    input logic          clk,
    input logic          rst_n,
    input logic          stop_req,
    input logic          card_clk,
    input logic          sel_err,
    input logic [2:0]    dck_sel,
    input ccg_pkg::dck_t dck_act,
    input ccg_pkg::sel_t sel_tgt,
    input ccg_pkg::sel_t sel_act
);
    import ccg_pkg::*;

    assert_switch_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_act != $past(sel_act)) |-> (!card_clk && !$past(card_clk)));

    assert_stop_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !card_clk) |=> !card_clk);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err |=> sel_err);

    assert_rsvd_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dck_sel == 3'd7) |=> $stable(dck_act));

    assert_group_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_alt(sel_tgt) != is_alt($past(sel_tgt))) |-> $past(stop_req));

    assert_div1_alt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dck_act == DCK_DIV1) |-> is_alt(sel_tgt));
endmodule

bind ccg_card_clk ccg_checker i_ccg_checker (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .card_clk(card_clk),
    .sel_err(sel_err), .dck_sel(dck_sel), .dck_act(dck_act),
    .sel_tgt(sel_tgt), .sel_act(sel_act)
);

// File: tb/test_ccg_card_clk.sv
module test_ccg_card_clk;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alt_clk = 1'b0;
    logic [2:0] dck_sel = 3'd1;
    logic [2:0] cclk_sel = 3'd0;
    logic       stop_req = 1'b0;
    logic       dcdc_clk, card_clk, sel_err;
    int         checks = 0;
    int         errors = 0;

    ccg_card_clk i_ccg_card_clk (
        .clk(clk), .rst_n(rst_n), .alt_clk(alt_clk), .dck_sel(dck_sel),
        .cclk_sel(cclk_sel), .stop_req(stop_req), .dcdc_clk(dcdc_clk),
        .card_clk(card_clk), .sel_err(sel_err)
    );

    always #4 clk = ~clk;

    // alternate clock: period 10 clk cycles
    initial begin
        forever begin
            repeat (5) @(negedge clk);
            alt_clk = ~alt_clk;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic logic pick(input bit use_card);
        return use_card ? card_clk : dcdc_clk;
    endfunction

    task automatic wait_rise(input bit use_card);
        logic prev;
        @(negedge clk);
        prev = pick(use_card);
        for (int g = 0; g < 3000; g++) begin
            @(negedge clk);
            if (!prev && pick(use_card)) return;
            prev = pick(use_card);
        end
    endtask

    task automatic measure(input bit use_card, output int per, output int hi);
        logic prev;
        wait_rise(use_card);
        per = 1; hi = 1; prev = 1'b1;
        while (per < 3000) begin
            @(negedge clk);
            if (!prev && pick(use_card)) break;
            if (pick(use_card)) hi++;
            per++;
            prev = pick(use_card);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; dck_sel = 3'd1; cclk_sel = 3'd0; stop_req = 1'b0;
        tick(3);
        check("R1 card_clk in reset", card_clk, 0);
        check("R1 dcdc_clk in reset", dcdc_clk, 0);
        check("R1 sel_err in reset", sel_err, 0);
        rst_n = 1'b1;
        tick(4);
    endtask

    function automatic int half_of(input int c);
        return (c == 0) ? 1 : 2 * c;
    endfunction

    function automatic int card_per(input int s, input int h);
        case (s)
            0: return 2;
            1: return 2 * h;
            2: return 4 * h;
            3: return 8 * h;
            6: return 4;
            default: return 8;
        endcase
    endfunction

    initial begin
        int per, hi, cnt;
        int sels[6] = '{0, 6, 7, 1, 2, 3};

        do_reset();
        measure(0, per, hi);
        check("R1 dcdc period after reset", per, 4);
        measure(1, per, hi);
        check("R1 card period after reset", per, 2);

        // R2 / R4 sweep over prescaler codes 1..6 and master-group sources
        for (int c = 1; c <= 6; c++) begin
            dck_sel = 3'(c);
            tick(60);
            measure(0, per, hi);
            check($sformatf("R2 dcdc period code %0d", c), per, 2 * half_of(c));
            check($sformatf("R2 dcdc high code %0d", c), hi, half_of(c));
            for (int k = 0; k < 6; k++) begin
                int e;
                cclk_sel = 3'(sels[k]);
                e = card_per(sels[k], half_of(c));
                tick(3 * e + 120);
                measure(1, per, hi);
                check($sformatf("R4 card period sel %0d code %0d", sels[k], c), per, e);
                check($sformatf("R4 card high sel %0d code %0d", sels[k], c), hi, e / 2);
            end
        end
        check("R4 no error on legal sweep", sel_err, 0);

        // R5: switch from a slow source during its high phase
        dck_sel = 3'd1; tick(20);
        cclk_sel = 3'd3; tick(60);
        wait_rise(1);
        cnt = 1;
        repeat (2) begin @(negedge clk); if (card_clk) cnt++; end
        cclk_sel = 3'd0;
        while (cnt < 100) begin
            @(negedge clk);
            if (!card_clk) break;
            cnt++;
        end
        check("R5 high phase kept whole", cnt, 8);
        tick(20);
        measure(1, per, hi);
        check("R5 new source after switch", per, 2);

        // R9: stop parks low, release gives a full first high phase
        cclk_sel = 3'd7; tick(40);
        stop_req = 1'b1; tick(10);
        cnt = 0;
        repeat (40) begin @(negedge clk); if (!card_clk) cnt++; end
        check("R9 parked low", cnt, 40);
        stop_req = 1'b0;
        wait_rise(1);
        cnt = 1;
        while (cnt < 100) begin
            @(negedge clk);
            if (!card_clk) break;
            cnt++;
        end
        check("R9 first high after release", cnt, 4);
        measure(1, per, hi);
        check("R9 period after release", per, 8);

        // R8: priming the alternate group
        stop_req = 1'b1; tick(20);
        cclk_sel = 3'd5; tick(10);
        stop_req = 1'b0; tick(30);
        measure(1, per, hi);
        check("R8 prime alone does not switch", per, 8);
        check("R8 prime raises no error", sel_err, 0);
        stop_req = 1'b1; tick(20);
        cclk_sel = 3'd4; tick(10);
        stop_req = 1'b0; tick(40);
        measure(1, per, hi);
        check("R4 alternate period", per, 10);
        check("R4 alternate high", hi, 5);

        // R11: free switching inside the group while running
        cclk_sel = 3'd5; tick(60);
        measure(1, per, hi);
        check("R11 alternate/2 period", per, 20);
        check("R11 no error inside group", sel_err, 0);

        // R2 code 0 is legal in the alternate group
        dck_sel = 3'd0; tick(20);
        measure(0, per, hi);
        check("R2 dcdc period code 0", per, 2);
        check("R2 dcdc high code 0", hi, 1);
        check("R2 code 0 no error", sel_err, 0);

        // R7: leaving the group while at code 0 is refused
        stop_req = 1'b1; tick(40);
        cclk_sel = 3'd0; tick(10);
        stop_req = 1'b0; tick(60);
        measure(1, per, hi);
        check("R7 source kept", per, 20);
        check("R7 error set", sel_err, 1);
        dck_sel = 3'd2; tick(100);
        check("R10 error sticky", sel_err, 1);

        // R6: group change while running
        do_reset();
        cclk_sel = 3'd4; tick(40);
        measure(1, per, hi);
        check("R6 source kept", per, 2);
        check("R6 error set", sel_err, 1);

        // R3: reserved prescaler code
        do_reset();
        dck_sel = 3'd7; tick(40);
        measure(0, per, hi);
        check("R3 divider kept", per, 4);
        check("R3 error set", sel_err, 1);

        // R7: code 0 refused under a master-group source
        do_reset();
        dck_sel = 3'd0; tick(40);
        measure(0, per, hi);
        check("R7 divider kept", per, 4);
        check("R7 error set on prescaler", sel_err, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1..all watchdog got running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule